// File: doc/BRIEF.md
# Bus Error and Timeout Status Register

This block keeps the error state of a system backplane controller. It watches three kinds of fault event: a bus timeout, an error confirmation from the bus, and a corrected-read-data report from memory. For each event it keeps a sticky flag that software can read. When the first timeout occurs, the block latches the longword address of the failed access, and for a virtual reference it also latches the access mode. Any later fault of a kind that is already flagged sets a multiple-error flag and overwrites no captured state.

Software clears the flags with write-one-to-clear. Some of these clears are grouped: clearing the timeout flag also clears the confirmation and multiple-error flags. The block raises a machine-check request for read timeouts and error confirmations, and a memory-error interrupt for write timeouts. It drives a corrected-data interrupt while that condition is both flagged and enabled. A completion strobe from the machine-check sequencer clears the timeout group.

Every event input is a single-cycle pulse and is accepted in the cycle it arrives. No input can be stalled, so the block has no back-pressure and no valid/ready handshake. A register write is also taken in its own cycle. The status and captured-address outputs are registers, and they show the effect of a cycle's inputs after the next rising edge.

Top module: `bus_err_log`

## Requirements
- R1: After reset, `status_o`, `tmo_addr_o`, `crd_irq`, `mchk_req` and `memerr_irq` are all zero.
- R2: A timeout pulse that arrives while status bit 12 is clear loads `tmo_addr_o` with the access address shifted right by two and sets bit 12. Both changes are visible after the next clock edge.
- R3: When the timeout is a virtual reference (`tmo_virt`=1), the captured value also has bit 29 set, and bits 31:30 hold `cur_mode`.
- R4: A timeout pulse that arrives while bit 12 is set leaves `tmo_addr_o` unchanged and sets bit 2, the multiple-error flag.
- R5: An error-confirm pulse sets bit 8 if bit 8 is clear, or sets bit 2 if bit 8 is already set.
- R6: `status_o` only ever has bits set within mask 0xFDFE. Bit 15, the corrected-data interrupt enable, takes the written value on every register write. Writing a one to bit 8 alone leaves bit 8 unchanged.
- R7: A write clears every bit where the written data has a one inside mask 0x70C0. This covers bit 14, the corrected-data flag, and bit 12, the timeout flag.
- R8: Writing a one to bit 12 also clears bits 8 and 2. Writing a one to bit 6 also clears bit 3 and bits 11:10.
- R9: `crd_irq` is high exactly when status bits 15 and 14 are both set. A corrected-data pulse sets bit 14.
- R10: A `mchk_done` pulse clears bits 12, 8 and 2.
- R11: A read timeout or an error confirmation makes `mchk_req` high for one cycle after the next edge. A write timeout does the same with `memerr_irq` and does not raise `mchk_req`.
- R12: When an event pulse and a clearing write or `mchk_done` occur in the same cycle, the bit that the event sets ends up set. The event is judged against the flag values held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_evt | input | 1 | Bus timeout pulse |
| tmo_addr_i | input | ADDR_W | Physical byte address of the timed-out access |
| tmo_virt | input | 1 | Timed-out access was a virtual reference |
| tmo_is_write | input | 1 | Timed-out access was a write |
| cur_mode | input | 2 | Current access mode |
| cnf_evt | input | 1 | Error-confirm pulse |
| crd_evt | input | 1 | Corrected-read-data pulse |
| mchk_done | input | 1 | Machine-check frame complete pulse |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Status register write data |
| status_o | output | 32 | Status register, read view |
| tmo_addr_o | output | ADDR_W | Captured timeout address |
| crd_irq | output | 1 | Corrected-data interrupt request |
| mchk_req | output | 1 | Machine-check request pulse |
| memerr_irq | output | 1 | Memory-error interrupt pulse |

## Verification
The checker watches several rules on every cycle: address capture on a first timeout, the virtual-mode fields, address hold and multiple-error flagging on a repeat timeout, the link between the interrupt and bits 15 and 14, the group clear on frame completion, and routing of each event to a machine check or a memory-error interrupt. Some behaviour only the bench's scenarios can show. These are the masked write semantics (a one in bit 8 that clears nothing, a write to bit 15 that survives clear bits) and the grouped clear through bit 12. Same-cycle collisions between an event and a clear, together with exact register values over a sequence of faults, also rest on the bench.

// File: rtl/berr_pkg.sv
package berr_pkg;
  localparam int STAT_W   = 32;
  localparam int B_CRD_IE = 15;
  localparam int B_CRD    = 14;
  localparam int B_TMO    = 12;
  localparam int B_CNF    = 8;
  localparam int B_MULT   = 2;
  localparam logic [STAT_W-1:0] READ_MASK = 32'h0000_FDFE;
  localparam logic [STAT_W-1:0] W1C_MASK  = 32'h0000_70C0;

  typedef struct packed {
    logic crd_ie;
    logic crd;
    logic tmo;
    logic cnf;
    logic mult;
  } flags_t;
endpackage

// File: rtl/berr_capture.sv
module berr_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              virt_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int VIRT_BIT = ADDR_W - 3;
  localparam int MODE_LSB = ADDR_W - 2;

  logic [ADDR_W-1:0] cap_next;

  always_comb begin
    cap_next = {2'b00, addr_i[ADDR_W-1:2]};
    if (virt_i) begin
      cap_next[VIRT_BIT] = 1'b1;
      cap_next[MODE_LSB +: 2] = mode_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (cap_en) addr_q <= cap_next;
  end
endmodule

// File: rtl/berr_flags.sv
module berr_flags
  import berr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_evt,
  input  logic              cnf_evt,
  input  logic              crd_evt,
  input  logic              mchk_done,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output flags_t            flags_q,
  output logic              cap_en,
  output logic              crd_irq
);
  flags_t            nxt;
  logic [STAT_W-1:0] clr;

  assign clr    = reg_wr ? (reg_wdata & W1C_MASK) : '0;
  assign cap_en = tmo_evt && !flags_q.tmo;

  always_comb begin
    nxt = flags_q;
    // software clears first
    if (reg_wr) nxt.crd_ie = reg_wdata[B_CRD_IE];
    if (clr[B_CRD]) nxt.crd = 1'b0;
    if (clr[B_TMO]) begin
      nxt.tmo  = 1'b0;
      nxt.cnf  = 1'b0;
      nxt.mult = 1'b0;
    end
    if (mchk_done) begin
      nxt.tmo  = 1'b0;
      nxt.cnf  = 1'b0;
      nxt.mult = 1'b0;
    end
    // events override clears, judged on held state
    if (crd_evt) nxt.crd = 1'b1;
    if (tmo_evt) begin
      if (flags_q.tmo) nxt.mult = 1'b1;
      else             nxt.tmo  = 1'b1;
    end
    if (cnf_evt) begin
      if (flags_q.cnf) nxt.mult = 1'b1;
      else             nxt.cnf  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= nxt;
  end

  assign crd_irq = flags_q.crd_ie & flags_q.crd;
endmodule

// File: rtl/berr_req.sv
module berr_req (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_evt,
  input  logic tmo_is_write,
  input  logic cnf_evt,
  output logic mchk_req,
  output logic memerr_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mchk_req   <= 1'b0;
      memerr_irq <= 1'b0;
    end else begin
      mchk_req   <= (tmo_evt && !tmo_is_write) || cnf_evt;
      memerr_irq <= tmo_evt && tmo_is_write;
    end
  end
endmodule

// File: rtl/bus_err_log.sv
module bus_err_log
  import berr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_evt,
  input  logic [ADDR_W-1:0] tmo_addr_i,
  input  logic              tmo_virt,
  input  logic              tmo_is_write,
  input  logic [1:0]        cur_mode,
  input  logic              cnf_evt,
  input  logic              crd_evt,
  input  logic              mchk_done,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] status_o,
  output logic [ADDR_W-1:0] tmo_addr_o,
  output logic              crd_irq,
  output logic              mchk_req,
  output logic              memerr_irq
);
  flags_t            flags;
  logic              cap_en;
  logic [STAT_W-1:0] raw;

  berr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .cnf_evt(cnf_evt),
    .crd_evt(crd_evt), .mchk_done(mchk_done), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .flags_q(flags), .cap_en(cap_en), .crd_irq(crd_irq)
  );

  berr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .addr_i(tmo_addr_i),
    .virt_i(tmo_virt), .mode_i(cur_mode), .addr_q(tmo_addr_o)
  );

  berr_req u_req (
    .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .tmo_is_write(tmo_is_write),
    .cnf_evt(cnf_evt), .mchk_req(mchk_req), .memerr_irq(memerr_irq)
  );

  always_comb begin
    raw           = '0;
    raw[B_CRD_IE] = flags.crd_ie;
    raw[B_CRD]    = flags.crd;
    raw[B_TMO]    = flags.tmo;
    raw[B_CNF]    = flags.cnf;
    raw[B_MULT]   = flags.mult;
  end

  assign status_o = raw & READ_MASK;
endmodule

// File: rtl/bus_err_log_chk.sv
module bus_err_log_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmo_evt,
  input logic [ADDR_W-1:0] tmo_addr_i,
  input logic              tmo_virt,
  input logic              tmo_is_write,
  input logic [1:0]        cur_mode,
  input logic              cnf_evt,
  input logic              mchk_done,
  input logic              reg_wr,
  input logic [31:0]       status_o,
  input logic [ADDR_W-1:0] tmo_addr_o,
  input logic              crd_irq,
  input logic              mchk_req,
  input logic              memerr_irq
);
  assert_first_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && !status_o[12] && !tmo_virt) |=>
      (status_o[12] && tmo_addr_o == {2'b00, $past(tmo_addr_i[ADDR_W-1:2])}));

  assert_virt_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && !status_o[12] && tmo_virt) |=>
      (tmo_addr_o[ADDR_W-1:ADDR_W-3] == {$past(cur_mode), 1'b1}));

  assert_repeat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && status_o[12]) |=> ($stable(tmo_addr_o) && status_o[2]));

  assert_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnf_evt && !status_o[8]) |=> status_o[8]);

  always @(negedge clk) begin
    if (rst_n) begin
      assert_crd_irq_R9: assert (crd_irq == (status_o[15] && status_o[14]));
    end
  end

  assert_done_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mchk_done && !tmo_evt && !cnf_evt) |=> (!status_o[12] && !status_o[8] && !status_o[2]));

  assert_read_mchk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && !tmo_is_write) |=> mchk_req);

  assert_write_memerr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && tmo_is_write && !cnf_evt) |=> (memerr_irq && !mchk_req));

  assert_event_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && tmo_evt && !status_o[12]) |=> status_o[12]);
endmodule

bind bus_err_log bus_err_log_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .tmo_addr_i(tmo_addr_i),
  .tmo_virt(tmo_virt), .tmo_is_write(tmo_is_write), .cur_mode(cur_mode),
  .cnf_evt(cnf_evt), .mchk_done(mchk_done), .reg_wr(reg_wr),
  .status_o(status_o), .tmo_addr_o(tmo_addr_o), .crd_irq(crd_irq),
  .mchk_req(mchk_req), .memerr_irq(memerr_irq)
);

// File: tb/bus_err_log_tb.sv
`timescale 1ns/1ps
module bus_err_log_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmo_evt = 1'b0, tmo_virt = 1'b0, tmo_is_write = 1'b0;
  logic [31:0] tmo_addr_i = '0;
  logic [1:0]  cur_mode = '0;
  logic        cnf_evt = 1'b0, crd_evt = 1'b0, mchk_done = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status_o, tmo_addr_o;
  logic        crd_irq, mchk_req, memerr_irq;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  bus_err_log #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .tmo_addr_i(tmo_addr_i),
    .tmo_virt(tmo_virt), .tmo_is_write(tmo_is_write), .cur_mode(cur_mode),
    .cnf_evt(cnf_evt), .crd_evt(crd_evt), .mchk_done(mchk_done),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .status_o(status_o),
    .tmo_addr_o(tmo_addr_o), .crd_irq(crd_irq), .mchk_req(mchk_req),
    .memerr_irq(memerr_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, applied at a negedge, results sampled at the next negedge
  task automatic cyc(input logic t, input logic [31:0] a, input logic v, input logic w,
                     input logic [1:0] m, input logic c, input logic d, input logic done,
                     input logic we, input logic [31:0] wd);
    tmo_evt = t; tmo_addr_i = a; tmo_virt = v; tmo_is_write = w; cur_mode = m;
    cnf_evt = c; crd_evt = d; mchk_done = done; reg_wr = we; reg_wdata = wd;
    @(negedge clk);
    tmo_evt = 0; cnf_evt = 0; crd_evt = 0; mchk_done = 0; reg_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 status", status_o, 32'h0);
    chk("R1 addr", tmo_addr_o, 32'h0);
    chk("R1 outs", {29'b0, crd_irq, mchk_req, memerr_irq}, 32'h0);
  endtask

  task automatic t_timeouts;
    cyc(1, 32'h2000_1234, 0, 0, 2'b00, 0, 0, 0, 0, 0);
    chk("R2 addr", tmo_addr_o, 32'h0800_048D);
    chk("R2 status", status_o, 32'h0000_1000);
    chk("R11 read mchk", {30'b0, mchk_req, memerr_irq}, 32'h2);
    cyc(1, 32'h3000_0000, 1, 1, 2'b11, 0, 0, 0, 0, 0);
    chk("R4 addr hold", tmo_addr_o, 32'h0800_048D);
    chk("R4 mult", status_o, 32'h0000_1004);
    chk("R11 write memerr", {30'b0, mchk_req, memerr_irq}, 32'h1);
    @(negedge clk);
    chk("R11 pulse width", {30'b0, mchk_req, memerr_irq}, 32'h0);
  endtask

  task automatic t_confirm_and_done;
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 cnf set", status_o, 32'h0000_1104);
    chk("R11 cnf mchk", {31'b0, mchk_req}, 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0104);
    chk("R6 bit8 not w1c", status_o, 32'h0000_1104);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R10 done clear", status_o, 32'h0);
  endtask

  task automatic t_virtual;
    cyc(1, 32'h0000_0010, 1, 0, 2'b11, 0, 0, 0, 0, 0);
    chk("R3 virt addr", tmo_addr_o, 32'hE000_0004);
    chk("R2 status", status_o, 32'h0000_1000);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1000);
    chk("R7 tmo w1c", status_o, 32'h0);
  endtask

  task automatic t_group_clear;
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 first cnf", status_o, 32'h0000_0100);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 second cnf", status_o, 32'h0000_0104);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1000);
    chk("R8 group clear", status_o, 32'h0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R6 read mask", status_o, 32'h0000_8000);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0000);
    chk("R6 ie write", status_o, 32'h0);
  endtask

  task automatic t_crd;
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9 crd flag", status_o, 32'h0000_4000);
    chk("R9 no irq", {31'b0, crd_irq}, 32'h0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_8000);
    chk("R9 irq", {31'b0, crd_irq}, 32'h1);
    chk("R6 ie set", status_o, 32'h0000_C000);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_C000);
    chk("R7 crd w1c", status_o, 32'h0000_8000);
    chk("R9 irq off", {31'b0, crd_irq}, 32'h0);
  endtask

  task automatic t_collide;
    cyc(1, 32'h0000_0400, 0, 0, 2'b01, 0, 1, 0, 1, 32'h0000_D000);
    chk("R12 tmo survives", status_o, 32'h0000_D000);
    chk("R12 addr", tmo_addr_o, 32'h0000_0100);
    chk("R12 irq", {31'b0, crd_irq}, 32'h1);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    chk("R12 cnf over done", status_o, 32'h0000_C100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timeouts();
    t_confirm_and_done();
    t_virtual();
    t_group_clear();
    t_crd();
    t_collide();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule